// File: doc/BRIEF.md
# Compare-Match Timer with Pin Control

An 8-bit up-counter advances on enable pulses from a selectable clock divider and is compared against a programmable match register. In free-running mode it wraps from its maximum value back to zero. In match-restart mode it returns to zero on the advance that finds it equal to the match register. A four-way action field chooses what each match does to an internal compare-output bit: nothing, invert it, force it low or force it high. Each match also sets a sticky flag.

The block drives one device pin. When the action field is nonzero, the compare-output bit replaces the general-purpose value on that pin. The output driver follows the pin's direction input. Software reaches four byte-wide registers through a single-cycle write strobe and a combinational read mux. Writing the counter blocks a match on the next advance, so loading the counter with the match value causes no pin action.

Top module: `tmr8_cmp`

## Requirements
- R1: After reset, every register reads zero, `cmp_flag` is 0, `pin_out` equals `port_out` and the counter holds still. The registers are control (address 0), counter (1), match (2) and flag (3).
- R2: `clk_sel` picks the advance rate: 0 means stopped, 1 means every clock, 2 means every 8th, 3 every 64th and 4 every 256th. Codes 5 to 7 also mean stopped. A free-running 8-bit divider starts at zero when reset is released and goes up by one every clock. An advance happens in a clock whose divider low 3, 6 or 8 bits are all ones. When stopped, the counter keeps its value.
- R3: The wave field is control bits 1:0. With any wave value other than 2'b10, each advance adds one to the counter, and 255 wraps to 0.
- R4: With wave value 2'b10, an advance on which the counter equals the match register loads zero instead of adding one.
- R5: A match is an advance on which the counter equals the match register. The action field is control bits 7:6: 01 inverts the compare-output bit, 10 clears it and 11 sets it. The result shows on `pin_out` in the clock after the match, which is the same clock in which the counter update shows.
- R6: With action field 00, `pin_out` equals `port_out`, and matches leave the compare-output bit unchanged. With any other action value, `pin_out` shows the compare-output bit.
- R7: `pin_oe` equals `pin_dir` at all times.
- R8: Flag register bit 0 is set by a match and stays set. Writing a 1 to bit 0 clears it, and writing a 0 has no effect. If a match and a clearing write fall in the same clock, the flag is set. `cmp_flag` mirrors this bit.
- R9: A counter write loads the written value, and the write wins over an advance in the same clock. The first advance after the write cannot produce a match: no pin action, no flag and no restart. The counter adds one on that advance.
- R10: Control bits 5:2 are read-only and read as zero. Flag register bits 7:1 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| clk_sel | input | 3 | Advance-rate select |
| port_out | input | 1 | General-purpose value for the pin |
| pin_dir | input | 1 | Pin direction, 1 enables the driver |
| pin_out | output | 1 | Value presented to the pin |
| pin_oe | output | 1 | Pin output enable |
| cmp_flag | output | 1 | Sticky compare flag |

## Verification
The hardest state to reach is a counter write or a flag clear landing in the same clock as a match. Directed stretches run at divide-by-one with a small match value, so matches come every few clocks. The bench writes the counter with the match value while advances are running, and it issues clear writes on every clock through several match-restart cycles. A seeded random phase then mixes rates, writes and pin inputs against a cycle model of the requirements.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_CLEAR  = 2'b10,
        OM_SET    = 2'b11
    } om_e;

    typedef enum logic [1:0] {
        A_CTRL  = 2'b00,
        A_COUNT = 2'b01,
        A_CMP   = 2'b10,
        A_FLAG  = 2'b11
    } addr_e;

    localparam logic [1:0] WAVE_CTC  = 2'b10;
    localparam logic [2:0] PS_DIV1   = 3'd1;
    localparam logic [2:0] PS_DIV8   = 3'd2;
    localparam logic [2:0] PS_DIV64  = 3'd3;
    localparam logic [2:0] PS_DIV256 = 3'd4;
endpackage

// File: rtl/tmr_presc.sv
`timescale 1ns/1ps
module tmr_presc #(
    parameter int DIV_W = 8,
    parameter int LO_W  = 3,
    parameter int MID_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);
    import tmr_pkg::*;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.div = st_q.div + 1'b1;
        unique case (sel)
            PS_DIV1:   tick = 1'b1;
            PS_DIV8:   tick = &st_q.div[LO_W-1:0];
            PS_DIV64:  tick = &st_q.div[MID_W-1:0];
            PS_DIV256: tick = &st_q.div;
            default:   tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tmr_cnt.sv
`timescale 1ns/1ps
module tmr_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         ctc,
    input  logic         wr_cnt,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] ocr,
    output logic [W-1:0] cnt,
    output logic         match
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         supp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        match = tick && !wr_cnt && !st_q.supp && (st_q.cnt == ocr);
        if (wr_cnt) begin
            st_d.cnt  = wr_val;
            st_d.supp = 1'b1;
        end else if (tick) begin
            st_d.supp = 1'b0;
            st_d.cnt  = (ctc && match) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(cnt));
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_cnt && !(ctc && match)) |=> (cnt == W'($past(cnt) + 1'b1)));
    a_r4_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (match && ctc) |=> (cnt == '0));
    a_r9_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(wr_val)));
    a_r9_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> !match);
endmodule

// File: rtl/tmr_oc.sv
`timescale 1ns/1ps
module tmr_oc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       match,
    input  logic [1:0] om,
    input  logic       port_out,
    input  logic       pin_dir,
    output logic       pin_out,
    output logic       pin_oe
);
    import tmr_pkg::*;

    typedef struct packed {
        logic oc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (match) begin
            unique case (om_e'(om))
                OM_TOGGLE: st_d.oc = ~st_q.oc;
                OM_CLEAR:  st_d.oc = 1'b0;
                OM_SET:    st_d.oc = 1'b1;
                default:   st_d.oc = st_q.oc;
            endcase
        end
        pin_out = (om != OM_OFF) ? st_q.oc : port_out;
        pin_oe  = pin_dir;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (match && om == OM_TOGGLE) |=> (st_q.oc != $past(st_q.oc)));
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (match && om == OM_CLEAR) |=> !st_q.oc);
    a_r5_set: assert property (@(posedge clk) disable iff (!rst_n)
        (match && om == OM_SET) |=> st_q.oc);
    a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (om == OM_OFF) |=> $stable(st_q.oc));
endmodule

// File: rtl/tmr8_cmp.sv
`timescale 1ns/1ps
module tmr8_cmp #(
    parameter int CNT_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic [2:0]       clk_sel,
    input  logic             port_out,
    input  logic             pin_dir,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             cmp_flag
);
    import tmr_pkg::*;

    localparam int PAD_W = CNT_W - 4;

    typedef struct packed {
        logic [1:0]       om;
        logic [1:0]       wave;
        logic [CNT_W-1:0] ocr;
        logic             flag;
    } regs_t;

    regs_t rg_d, rg_q;

    logic             tick;
    logic             match;
    logic             wr_cnt;
    logic [CNT_W-1:0] cnt;

    tmr_presc #(.DIV_W(DIV_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (clk_sel),
        .tick  (tick)
    );

    tmr_cnt #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .ctc    (rg_q.wave == WAVE_CTC),
        .wr_cnt (wr_cnt),
        .wr_val (bus_wdata),
        .ocr    (rg_q.ocr),
        .cnt    (cnt),
        .match  (match)
    );

    tmr_oc u_oc (
        .clk      (clk),
        .rst_n    (rst_n),
        .match    (match),
        .om       (rg_q.om),
        .port_out (port_out),
        .pin_dir  (pin_dir),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    always_comb begin
        rg_d   = rg_q;
        wr_cnt = bus_wr && (addr_e'(bus_addr) == A_COUNT);
        if (bus_wr) begin
            unique case (addr_e'(bus_addr))
                A_CTRL: begin
                    rg_d.om   = bus_wdata[7:6];
                    rg_d.wave = bus_wdata[1:0];
                end
                A_CMP:   rg_d.ocr = bus_wdata;
                A_FLAG:  if (bus_wdata[0]) rg_d.flag = 1'b0;
                default: ;
            endcase
        end
        if (match) rg_d.flag = 1'b1;

        unique case (addr_e'(bus_addr))
            A_CTRL:  bus_rdata = {rg_q.om, {PAD_W{1'b0}}, rg_q.wave};
            A_COUNT: bus_rdata = cnt;
            A_CMP:   bus_rdata = rg_q.ocr;
            default: bus_rdata = {{(CNT_W-1){1'b0}}, rg_q.flag};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign cmp_flag = rg_q.flag;

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> cmp_flag);
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_FLAG && bus_wdata[0] && !match) |=> !cmp_flag);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_flag && !(bus_wr && bus_addr == A_FLAG)) |=> cmp_flag);
endmodule

// File: tb/tmr8_cmp_test.sv
`timescale 1ns/1ps
module tmr8_cmp_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [2:0] clk_sel = 3'd0;
    logic       port_out = 1'b0;
    logic       pin_dir = 1'b0;
    logic       pin_out, pin_oe, cmp_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_tag = "R1";

    // reference state
    logic [7:0] m_cnt = 0, m_ocr = 0, m_div = 0;
    logic [1:0] m_om = 0, m_wave = 0;
    logic       m_supp = 0, m_oc = 0, m_flag = 0;

    always #10 clk = ~clk;

    tmr8_cmp uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_sel(clk_sel),
        .port_out(port_out), .pin_dir(pin_dir), .pin_out(pin_out),
        .pin_oe(pin_oe), .cmp_flag(cmp_flag)
    );

    function automatic logic exp_tick(input logic [2:0] s, input logic [7:0] d);
        case (s)
            3'd1:    return 1'b1;
            3'd2:    return &d[2:0];
            3'd3:    return &d[5:0];
            3'd4:    return &d;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {m_om, 4'b0000, m_wave};
            2'd1:    return m_cnt;
            2'd2:    return m_ocr;
            default: return {7'd0, m_flag};
        endcase
    endfunction

    task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_tag, what, act, exp);
        end
    endtask

    // one clock: drive inputs at the falling edge, compare, advance the model
    task automatic cyc(input logic w, input logic [1:0] a, input logic [7:0] d,
                       input logic [2:0] s, input logic po, input logic dr);
        logic t, wc, mt, nf, noc;
        logic [7:0] nc;
        bus_wr = w; bus_addr = a; bus_wdata = d; clk_sel = s;
        port_out = po; pin_dir = dr;
        #1;
        chk("pin_out", {7'd0, pin_out}, {7'd0, (m_om != 2'b00) ? m_oc : po});
        chk("pin_oe",  {7'd0, pin_oe},  {7'd0, dr});
        chk("cmp_flag", {7'd0, cmp_flag}, {7'd0, m_flag});
        chk("rdata", bus_rdata, exp_read(a));
        t  = exp_tick(s, m_div);
        wc = w && (a == 2'd1);
        mt = t && !wc && !m_supp && (m_cnt == m_ocr);
        nc = m_cnt;
        if (wc) begin nc = d; m_supp = 1'b1; end
        else if (t) begin
            m_supp = 1'b0;
            nc = (m_wave == 2'b10 && mt) ? 8'd0 : m_cnt + 8'd1;
        end
        noc = m_oc;
        if (mt) case (m_om)
            2'b01: noc = ~m_oc;
            2'b10: noc = 1'b0;
            2'b11: noc = 1'b1;
            default: ;
        endcase
        nf = m_flag;
        if (w && a == 2'd3 && d[0]) nf = 1'b0;
        if (mt) nf = 1'b1;
        if (w && a == 2'd0) begin m_om = d[7:6]; m_wave = d[1:0]; end
        if (w && a == 2'd2) m_ocr = d;
        m_cnt = nc; m_oc = noc; m_flag = nf; m_div = m_div + 8'd1;
        @(negedge clk);
    endtask

    task automatic idle(input int n, input logic [1:0] a, input logic [2:0] s, input logic dr);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 8'd0, s, i[1], dr);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        cur_tag = "R1";
        for (int a = 0; a < 4; a++) cyc(1'b0, a[1:0], 8'd0, 3'd0, 1'b1, 1'b0);

        cur_tag = "R2";
        cyc(1'b1, 2'd2, 8'd200, 3'd0, 0, 1);
        cyc(1'b1, 2'd1, 8'd0, 3'd0, 0, 1);
        idle(40, 2'd1, 3'd2, 1);
        idle(10, 2'd1, 3'd0, 1);
        idle(150, 2'd1, 3'd3, 1);
        idle(600, 2'd1, 3'd4, 1);
        idle(10, 2'd1, 3'd6, 1);

        cur_tag = "R3";
        cyc(1'b1, 2'd2, 8'd5, 3'd0, 0, 1);
        cyc(1'b1, 2'd1, 8'd250, 3'd0, 0, 1);
        for (int i = 0; i < 24; i++) cyc(1'b0, i[0] ? 2'd3 : 2'd1, 8'd0, 3'd1, 0, 1);

        cur_tag = "R4";
        cyc(1'b1, 2'd0, 8'b0100_0010, 3'd0, 0, 1);
        cyc(1'b1, 2'd2, 8'd3, 3'd0, 0, 1);
        cyc(1'b1, 2'd1, 8'd0, 3'd0, 0, 1);
        idle(20, 2'd1, 3'd1, 1);

        cur_tag = "R5";
        cyc(1'b1, 2'd2, 8'd2, 3'd1, 0, 1);
        cyc(1'b1, 2'd0, 8'b1000_0010, 3'd1, 0, 1);
        idle(8, 2'd1, 3'd1, 1);
        cyc(1'b1, 2'd0, 8'b1100_0010, 3'd1, 0, 1);
        idle(8, 2'd1, 3'd1, 1);
        cyc(1'b1, 2'd0, 8'b0100_0010, 3'd2, 0, 1);
        idle(40, 2'd1, 3'd2, 1);

        cur_tag = "R6";
        cyc(1'b1, 2'd0, 8'b0000_0010, 3'd1, 0, 1);
        for (int i = 0; i < 20; i++) cyc(1'b0, 2'd1, 8'd0, 3'd1, i[0], 1);
        cyc(1'b1, 2'd0, 8'b0100_0010, 3'd0, 1, 1);
        idle(4, 2'd1, 3'd0, 1);

        cur_tag = "R7";
        for (int i = 0; i < 12; i++) cyc(1'b0, 2'd1, 8'd0, 3'd1, i[1], i[0]);

        cur_tag = "R8";
        cyc(1'b1, 2'd2, 8'd4, 3'd1, 0, 1);
        for (int i = 0; i < 16; i++) cyc(1'b1, 2'd3, 8'd1, 3'd1, 0, 1);
        for (int i = 0; i < 8; i++) cyc(1'b1, 2'd3, 8'hFE, 3'd1, 0, 1);
        cyc(1'b1, 2'd3, 8'd1, 3'd0, 0, 1);
        idle(2, 2'd3, 3'd0, 1);

        cur_tag = "R9";
        cyc(1'b1, 2'd2, 8'd6, 3'd1, 0, 1);
        cyc(1'b1, 2'd1, 8'd6, 3'd1, 0, 1);
        for (int i = 0; i < 6; i++) cyc(1'b0, i[0] ? 2'd3 : 2'd1, 8'd0, 3'd1, 0, 1);
        cyc(1'b1, 2'd1, 8'd6, 3'd0, 0, 1);
        idle(3, 2'd1, 3'd0, 1);
        for (int i = 0; i < 4; i++) cyc(1'b0, i[0] ? 2'd3 : 2'd1, 8'd0, 3'd1, 0, 1);
        cyc(1'b1, 2'd1, 8'd6, 3'd2, 0, 1);
        idle(20, 2'd3, 3'd2, 1);

        cur_tag = "R10";
        cyc(1'b1, 2'd0, 8'hFF, 3'd0, 0, 1);
        cyc(1'b0, 2'd0, 8'd0, 3'd0, 0, 1);
        cyc(1'b0, 2'd3, 8'd0, 3'd1, 0, 1);
        idle(12, 2'd1, 3'd1, 1);

        cur_tag = "R5";
        for (int i = 0; i < 4000; i++) begin
            logic w;
            logic [1:0] a;
            logic [7:0] d;
            logic [2:0] s;
            w = ($urandom % 6) == 0;
            a = 2'($urandom);
            d = 8'($urandom);
            if (a == 2'd2 && w) d = d % 8'd12;
            if (a == 2'd1 && w && d[7]) d = m_ocr;
            s = (($urandom % 4) != 0) ? 3'd1 : 3'($urandom);
            cyc(w, a, d, s, 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule